// File: doc/BRIEF.md
# I/O Window Address Translator

This block sits between a processor-side memory window and an I/O bus. The processor reaches I/O ports by issuing loads and stores into an 8 MB window that starts at 0x8000_0000. For every request strobe the translator decides whether the address lies inside that window. If it does, the translator forms the I/O port address and passes the byte enables through unchanged. Byte, halfword and word accesses all use the same translation, and only the address is changed.

There are two mapping modes, chosen by a mode input. In contiguous mode the window behaves as one flat 64 KB port space, so the port address is the low 16 bits of the window offset. In sparse mode each 4 KB page of the window exposes only 32 ports. Offset bits 4:0 are kept, offset bits 22:12 move down to port bits 15:5, and offset bits 11:5 are dropped. Page-granular protection can then isolate groups of 32 ports.

The result is registered and appears one cycle after the strobe. A small state machine records the outcome of the last request. State `ST_IDLE` means no request was seen in the previous cycle. State `ST_HIT` means the last request translated. State `ST_MISS` means the last request fell outside the window. The transitions are:

- `REQ_IN` goes from any state to `ST_HIT`.
- `REQ_OUT` goes from any state to `ST_MISS`.
- `NO_REQ` goes from any state to `ST_IDLE`.

The mode input is sampled on the strobe edge together with the address.

Top module: `iowin_xlate`

## Requirements
- R1: A request whose address lies in 0x8000_0000 through 0x807F_FFFF, both bounds included, produces `rsp_hit`=1 and `port_stb`=1 in the response cycle.
- R2: With `map_sparse`=0, a hit yields `port_addr` equal to request address bits 15:0.
- R3: With `map_sparse`=1, a hit yields `port_addr` bits 4:0 equal to address bits 4:0 and `port_addr` bits 15:5 equal to address bits 22:12. Address bits 11:5 have no effect.
- R4: A request outside the window produces `rsp_vld`=1, `rsp_hit`=0, `port_stb`=0, `port_addr`=0 and `port_be`=0.
- R5: Outputs for a request appear in the cycle after the clock edge that samples `req_vld`=1. Back-to-back strobes produce back-to-back responses, one per strobe.
- R6: On a hit, `port_be` equals the request byte enables for any enable pattern (byte, halfword or word).
- R7: `map_sparse` is sampled only with the strobe. A change in the following cycle does not alter the response that is already registered.
- R8: During and right after reset, `rsp_vld`, `rsp_hit`, `port_stb`, `port_addr` and `port_be` are all 0.
- R9: A cycle without a strobe returns all outputs to 0 in the next cycle, whatever the address, enables and mode inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_addr | input | 32 | Processor-side request address |
| req_be | input | 4 | Request byte enables |
| map_sparse | input | 1 | Mode select: 0 contiguous, 1 sparse |
| rsp_vld | output | 1 | A response is present this cycle |
| rsp_hit | output | 1 | The response's address was in the window |
| port_stb | output | 1 | I/O port access strobe (valid and hit) |
| port_addr | output | 16 | Translated I/O port address |
| port_be | output | 4 | Byte enables passed to the I/O bus |

## Verification
The bench builds the block with its default parameters: a 32-bit request address, a window of 2^23 bytes based at 0x8000_0000, 4 KB pages holding 32 ports each, and a 16-bit port address. With these values, both window edges and the first addresses beyond them fall inside a handful of vectors. A sparse-mode address with every page bit set fills every port bit. The dropped offset bits 11:5 can be set while the expected result stays known.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } xl_state_e;

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode #(
    parameter int unsigned         ADDR_W   = 32,
    parameter int unsigned         WIN_LOG2 = 23,
    parameter logic [ADDR_W-1:0]   WIN_BASE = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                in_win,
    output logic [WIN_LOG2-1:0] offset
);
    localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;
    localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

    always_comb begin
        in_win = (addr[ADDR_W-1:WIN_LOG2] == BASE_TAG);
        offset = addr[WIN_LOG2-1:0];
    end
endmodule

// File: rtl/iowin_remap.sv
module iowin_remap #(
    parameter int unsigned WIN_LOG2  = 23,
    parameter int unsigned PAGE_LOG2 = 12,
    parameter int unsigned LOW_W     = 5,
    parameter int unsigned PORT_W    = 16
) (
    input  logic [WIN_LOG2-1:0] offset,
    input  logic                sparse,
    output logic [PORT_W-1:0]   port
);
    localparam int unsigned HIGH_W = WIN_LOG2 - PAGE_LOG2;

    logic [PORT_W-1:0] flat_port;
    logic [PORT_W-1:0] sparse_port;

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        if (i < WIN_LOG2) begin : g_flat
            assign flat_port[i] = offset[i];
        end else begin : g_flat_pad
            assign flat_port[i] = 1'b0;
        end

        if (i < LOW_W) begin : g_low
            assign sparse_port[i] = offset[i];
        end else if (i < LOW_W + HIGH_W) begin : g_high
            assign sparse_port[i] = offset[i - LOW_W + PAGE_LOG2];
        end else begin : g_pad
            assign sparse_port[i] = 1'b0;
        end
    end

    always_comb begin
        port = sparse ? sparse_port : flat_port;
    end
endmodule

// File: rtl/iowin_fsm.sv
module iowin_fsm
    import iowin_pkg::*;
#(
    parameter int unsigned PORT_W = 16,
    parameter int unsigned BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              in_win,
    input  logic [PORT_W-1:0] xl_port,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic              port_stb,
    output logic [PORT_W-1:0] port_addr,
    output logic [BE_W-1:0]   port_be
);
    xl_state_e         state_q, state_d;
    logic [PORT_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (!req_vld)     state_d = ST_IDLE;
                else if (in_win)  state_d = ST_HIT;
                else              state_d = ST_MISS;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            be_q   <= '0;
        end else if (req_vld && in_win) begin
            addr_q <= xl_port;
            be_q   <= req_be;
        end else begin
            addr_q <= '0;
            be_q   <= '0;
        end
    end

    always_comb begin
        rsp_vld   = 1'b0;
        rsp_hit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_vld = 1'b0;
                rsp_hit = 1'b0;
            end
            ST_HIT: begin
                rsp_vld = 1'b1;
                rsp_hit = 1'b1;
            end
            ST_MISS: begin
                rsp_vld = 1'b1;
                rsp_hit = 1'b0;
            end
            default: begin
                rsp_vld = 1'b0;
                rsp_hit = 1'b0;
            end
        endcase
        port_stb  = rsp_vld && rsp_hit;
        port_addr = addr_q;
        port_be   = be_q;
    end

    p_resp_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    p_idle_after_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && port_addr == '0 && port_be == '0));
    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !in_win) |=> (!port_stb && port_addr == '0 && port_be == '0));
    p_be_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && in_win) |=> (port_stb && port_be == $past(req_be)));
endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate #(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       WIN_LOG2  = 23,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
    parameter int unsigned       PAGE_LOG2 = 12,
    parameter int unsigned       LOW_W     = 5,
    parameter int unsigned       PORT_W    = 16,
    parameter int unsigned       BE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic              map_sparse,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic              port_stb,
    output logic [PORT_W-1:0] port_addr,
    output logic [BE_W-1:0]   port_be
);
    localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;

    logic                in_win;
    logic [WIN_LOG2-1:0] offset;
    logic [PORT_W-1:0]   xl_port;

    iowin_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (WIN_LOG2),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .addr   (req_addr),
        .in_win (in_win),
        .offset (offset)
    );

    iowin_remap #(
        .WIN_LOG2  (WIN_LOG2),
        .PAGE_LOG2 (PAGE_LOG2),
        .LOW_W     (LOW_W),
        .PORT_W    (PORT_W)
    ) u_remap (
        .offset (offset),
        .sparse (map_sparse),
        .port   (xl_port)
    );

    iowin_fsm #(
        .PORT_W (PORT_W),
        .BE_W   (BE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .in_win    (in_win),
        .xl_port   (xl_port),
        .req_be    (req_be),
        .rsp_vld   (rsp_vld),
        .rsp_hit   (rsp_hit),
        .port_stb  (port_stb),
        .port_addr (port_addr),
        .port_be   (port_be)
    );

    p_window_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2])
        |=> (rsp_hit && port_stb));
    p_flat_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !map_sparse && req_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2])
        |=> (port_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0])));
    p_sparse_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && map_sparse && req_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2])
        |=> (port_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0])));
    p_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_addr[ADDR_W-1:WIN_LOG2] != WIN_BASE[ADDR_W-1:WIN_LOG2])
        |=> (rsp_vld && !rsp_hit));
    p_stb_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        port_stb |-> $past(req_vld));
endmodule

// File: tb/iowin_xlate_bench.sv
module iowin_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic        map_sparse = 1'b0;
    logic        rsp_vld, rsp_hit, port_stb;
    logic [15:0] port_addr;
    logic [3:0]  port_be;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    iowin_xlate u_iowin_xlate (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld    (req_vld),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .map_sparse (map_sparse),
        .rsp_vld    (rsp_vld),
        .rsp_hit    (rsp_hit),
        .port_stb   (port_stb),
        .port_addr  (port_addr),
        .port_be    (port_be)
    );

    // vector: {sparse, addr[31:0], be[3:0], exp_hit, exp_port[15:0]}
    localparam int NV = 13;
    localparam logic [53:0] VEC [0:NV-1] = '{
        {1'b0, 32'h8000_03F8, 4'hF, 1'b1, 16'h03F8},
        {1'b0, 32'h807F_1234, 4'h1, 1'b1, 16'h1234},
        {1'b0, 32'h8000_0000, 4'h3, 1'b1, 16'h0000},
        {1'b0, 32'h807F_FFFF, 4'h8, 1'b1, 16'hFFFF},
        {1'b0, 32'h8080_0000, 4'hF, 1'b0, 16'h0000},
        {1'b0, 32'h7FFF_FFFF, 4'h2, 1'b0, 16'h0000},
        {1'b1, 32'h8000_0000, 4'hF, 1'b1, 16'h0000},
        {1'b1, 32'h8000_1000, 4'h4, 1'b1, 16'h0020},
        {1'b1, 32'h8000_0FFF, 4'h1, 1'b1, 16'h001F},
        {1'b1, 32'h807F_F01F, 4'hC, 1'b1, 16'hFFFF},
        {1'b1, 32'h8012_3456, 4'h6, 1'b1, 16'h2476},
        {1'b1, 32'hFFFF_0000, 4'hF, 1'b0, 16'h0000},
        {1'b1, 32'h0000_0100, 4'h1, 1'b0, 16'h0000}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_resp(input string req, input logic hit,
                              input logic [15:0] pa, input logic [3:0] be);
        check(req, "rsp_vld", {31'd0, rsp_vld}, 32'd1);
        check(req, "rsp_hit", {31'd0, rsp_hit}, {31'd0, hit});
        check(req, "port_stb", {31'd0, port_stb}, {31'd0, hit});
        check(req, "port_addr", {16'd0, port_addr}, {16'd0, pa});
        check(req, "port_be", {28'd0, port_be}, {28'd0, be});
    endtask

    task automatic check_idle(input string req);
        check(req, "idle rsp_vld", {31'd0, rsp_vld}, 32'd0);
        check(req, "idle port_stb", {31'd0, port_stb}, 32'd0);
        check(req, "idle port_addr", {16'd0, port_addr}, 32'd0);
        check(req, "idle port_be", {28'd0, port_be}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        #1;
        check_idle("R8");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_idle("R8");

        // Vector walk: R1 R2 R3 R4 R6
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            map_sparse = VEC[i][53];
            req_addr   = VEC[i][52:21];
            req_be     = VEC[i][20:17];
            req_vld    = 1'b1;
            @(posedge clk);
            #1;
            check(VEC[i][16] ? (VEC[i][53] ? "R3" : "R2") : "R4", "vector",
                  {15'd0, rsp_hit, port_addr}, {15'd0, VEC[i][16], VEC[i][15:0]});
            check_resp(VEC[i][16] ? "R1/R6" : "R4", VEC[i][16], VEC[i][15:0],
                       VEC[i][16] ? VEC[i][20:17] : 4'h0);
            @(negedge clk);
            req_vld = 1'b0;
            @(posedge clk);
            #1;
            check_idle("R9");
        end

        // R5: back-to-back strobes, hit then miss then hit
        @(negedge clk);
        map_sparse = 1'b0; req_addr = 32'h8000_0060; req_be = 4'h1; req_vld = 1'b1;
        @(posedge clk);
        #1;
        check_resp("R5", 1'b1, 16'h0060, 4'h1);
        @(negedge clk);
        req_addr = 32'h9000_0000; req_be = 4'hF;
        @(posedge clk);
        #1;
        check_resp("R5", 1'b0, 16'h0000, 4'h0);
        @(negedge clk);
        req_addr = 32'h8000_0064; req_be = 4'h3;
        @(posedge clk);
        #1;
        check_resp("R5", 1'b1, 16'h0064, 4'h3);
        @(negedge clk);
        req_vld = 1'b0;
        @(posedge clk);
        #1;
        check_idle("R5");

        // R7: mode flips after the strobe; registered result keeps old mode
        @(negedge clk);
        map_sparse = 1'b1; req_addr = 32'h8000_2FE5; req_be = 4'hF; req_vld = 1'b1;
        @(posedge clk);
        #1;
        map_sparse = 1'b0;
        req_vld = 1'b0;
        #5;
        check_resp("R7", 1'b1, 16'h0045, 4'hF);
        @(posedge clk);
        #1;
        check_idle("R7");

        // R9: in-window address, enables and mode toggling without strobe
        @(negedge clk);
        req_addr = 32'h8000_1234; req_be = 4'hF; map_sparse = 1'b1;
        @(posedge clk);
        #1;
        check_idle("R9");
        @(negedge clk);
        map_sparse = 1'b0;
        @(posedge clk);
        #1;
        check_idle("R9");

        // R8: reset during an active response clears outputs
        @(negedge clk);
        req_vld = 1'b1; req_addr = 32'h8000_0010;
        @(posedge clk);
        #1;
        check_resp("R8", 1'b1, 16'h0010, 4'hF);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_idle("R8");
        @(negedge clk);
        req_vld = 1'b0;
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule